// File: doc/BRIEF.md
# Multi-Channel Scan Sampler with Buffered Result Writer

This block runs conversion scans over a group of analog input channels and streams the results into system memory through a one-word write port. A sample trigger starts a scan that visits every enabled channel once, lowest index first. The scan asks an external converter for one channel at a time. The converter answers after a fixed number of cycles, and the block writes that result to the next memory word of the current buffer.

Buffer placement comes from a pair of registers: a staging copy that software may rewrite at any time, and a live copy that the block uses. A start trigger moves the staging values into the live copy. Software can therefore queue the next buffer as soon as the start acknowledge pulse appears. When the live buffer is full, the block raises a completion pulse. An optional auto-restart path turns that pulse straight into a new start, so buffers chain with no software action.

A scan can run past the end of a buffer. The unwritten channels of that scan then wait and go to the head of the following buffer. As a result, the channel order in memory rotates when the buffer length is not a whole number of scans. A stop trigger abandons the scan and closes the buffer early.

Top module: `scan_dma_sampler`

## Requirements
- R1: A scan writes one result per enabled channel, in ascending channel order, to consecutive words. The address starts at the live buffer pointer and grows by DATA_W/8 bytes per result.
- R2: A sample trigger is ignored while `busy` is high, and also when no channel is enabled: no converter request and no write result from it.
- R3: `busy` is high from the cycle after an accepted sample trigger until the scan's last result is written or the scan is aborted. `conv_req` is only ever high while `busy` is high.
- R4: A start trigger copies the staging pointer and length into the live buffer, clears `amount` and pulses `ev_started` for one cycle in the next cycle. Staging writes made after that do not change the live buffer.
- R5: When `amount` reaches the live length, `ev_end` pulses for one cycle and no further result is written until the next start.
- R6: With `autostart_en` high, the cycle after an `ev_end` pulse carries an `ev_started` pulse, and the staged buffer becomes live with no trigger.
- R7: `amount` equals the number of results written since the most recent start.
- R8: If a buffer fills mid-scan, the scan keeps `busy` high and holds its remaining channels. They become the first words of the next buffer, in the same ascending order.
- R9: While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady and the scan does not advance.
- R10: A stop trigger abandons the scan and drops any held result. If a buffer is live, it pulses `ev_end` with `amount` frozen at the count reached. No write follows until a new scan and start.
- R11: Each conversion is one single-cycle `conv_req` with the channel on `conv_ch`. The result is taken from `conv_data` in the cycle `conv_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | NUM_CH | Channel enable mask, sampled when a scan is accepted |
| autostart_en | input | 1 | Chain a new start onto every completion |
| trig_start | input | 1 | Start trigger (one-cycle pulse) |
| trig_sample | input | 1 | Sample trigger (one-cycle pulse) |
| trig_stop | input | 1 | Stop trigger (one-cycle pulse) |
| stage_wr | input | 1 | Write strobe for the staging pointer and length |
| stage_ptr | input | ADDR_W | Staging byte address of the next buffer |
| stage_len | input | CNT_W | Staging result count of the next buffer |
| ev_started | output | 1 | Start acknowledge pulse |
| ev_end | output | 1 | Buffer completion pulse |
| busy | output | 1 | Scan in progress |
| amount | output | CNT_W | Results written since the last start |
| conv_req | output | 1 | Converter request pulse |
| conv_ch | output | CH_W | Channel for the converter request |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result, signed |
| mem_valid | output | 1 | Write request to memory |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | DATA_W | Result word to write |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
The bench sweeps every non-empty channel mask over a two-scan buffer, with and without memory back-pressure. A design that got the priority pick or the address step wrong would show misordered channel tags or gaps in memory. A buffer of six words with four channels forces a scan across a buffer boundary. A design that dropped the held result, or wrote it into the full buffer, would fail to produce the rotated order 2,3,0,1 at the next buffer. The bench also issues a second trigger during a running scan, pulses stop between two conversions, and chains buffers automatically. Faults there would show up as extra converter requests, a stale result leaking after the abort, or a missing or late acknowledge one cycle after completion.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_REQ   = 3'd1,
      SQ_WAIT  = 3'd2,
      SQ_HOLD  = 3'd3,
      SQ_DRAIN = 3'd4
   } seq_state_t;

   function automatic int unsigned ch_index_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sdma_chan_pick.sv
// Lowest set channel of a mask, optionally restricted to indices above a floor.
module sdma_chan_pick #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 2
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   floor_ch,
   input  logic              use_floor,
   output logic              found,
   output logic [CH_W-1:0]   pick
);

   logic [NUM_CH-1:0] cand;

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cand
      assign cand[gi] = mask[gi] & (~use_floor | (CH_W'(gi) > floor_ch));
   end

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            pick  = CH_W'(i);
         end
      end
   end

endmodule

// File: rtl/sdma_buf_ctrl.sv
// Staging/live buffer registers, write address, result count and events.
module sdma_buf_ctrl #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned ADDR_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_start,
   input  logic              trig_stop,
   input  logic              chain_en,
   input  logic              stage_wr,
   input  logic [ADDR_W-1:0] stage_ptr,
   input  logic [CNT_W-1:0]  stage_len,
   input  logic              wr_fire,
   output logic              armed,
   output logic              ev_started,
   output logic              ev_end,
   output logic [CNT_W-1:0]  amount,
   output logic [ADDR_W-1:0] wr_addr
);

   localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
   localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(ADDR_STEP);

   logic [ADDR_W-1:0] stg_ptr_q;
   logic [CNT_W-1:0]  stg_len_q;
   logic [CNT_W-1:0]  live_len_q;
   logic [CNT_W-1:0]  amount_q;
   logic [ADDR_W-1:0] addr_q;
   logic              armed_q;
   logic              started_q;
   logic              end_q;
   logic              start_req;
   logic [CNT_W-1:0]  amount_inc;

   assign start_req  = trig_start | (chain_en & end_q);
   assign amount_inc = amount_q + CNT_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_ptr_q  <= '0;
         stg_len_q  <= '0;
         live_len_q <= '0;
         amount_q   <= '0;
         addr_q     <= '0;
         armed_q    <= 1'b0;
         started_q  <= 1'b0;
         end_q      <= 1'b0;
      end else begin
         started_q <= 1'b0;
         end_q     <= 1'b0;
         if (stage_wr) begin
            stg_ptr_q <= stage_ptr;
            stg_len_q <= stage_len;
         end
         if (start_req) begin
            live_len_q <= stg_len_q;
            addr_q     <= stg_ptr_q;
            amount_q   <= '0;
            armed_q    <= (stg_len_q != '0);
            started_q  <= 1'b1;
         end else if (trig_stop && armed_q) begin
            armed_q <= 1'b0;
            end_q   <= 1'b1;
         end else if (wr_fire) begin
            amount_q <= amount_inc;
            addr_q   <= addr_q + STEP_A;
            if (amount_inc == live_len_q) begin
               armed_q <= 1'b0;
               end_q   <= 1'b1;
            end
         end
      end
   end

   assign armed      = armed_q;
   assign ev_started = started_q;
   assign ev_end     = end_q;
   assign amount     = amount_q;
   assign wr_addr    = addr_q;

endmodule

// File: rtl/sdma_scan_seq.sv
// Channel scan sequencer: converter handshake and one held result.
module sdma_scan_seq
   import sdma_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 2,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_sample,
   input  logic              trig_stop,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              wr_fire,
   output logic              busy,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_ch,
   output logic              have_res,
   output logic [DATA_W-1:0] res_data
);

   seq_state_t        state_q;
   logic [NUM_CH-1:0] mask_q;
   logic [CH_W-1:0]   cur_q;
   logic [DATA_W-1:0] res_q;
   logic              first_found;
   logic [CH_W-1:0]   first_ch;
   logic              next_found;
   logic [CH_W-1:0]   next_ch;

   sdma_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick_first (
      .mask      (ch_enable),
      .floor_ch  ('0),
      .use_floor (1'b0),
      .found     (first_found),
      .pick      (first_ch)
   );

   sdma_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick_next (
      .mask      (mask_q),
      .floor_ch  (cur_q),
      .use_floor (1'b1),
      .found     (next_found),
      .pick      (next_ch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mask_q  <= '0;
         cur_q   <= '0;
         res_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (trig_sample && !trig_stop && first_found) begin
                  mask_q  <= ch_enable;
                  cur_q   <= first_ch;
                  state_q <= SQ_REQ;
               end
            end
            SQ_REQ: begin
               state_q <= trig_stop ? SQ_DRAIN : SQ_WAIT;
            end
            SQ_WAIT: begin
               if (conv_valid) begin
                  res_q   <= conv_data;
                  state_q <= trig_stop ? SQ_IDLE : SQ_HOLD;
               end else if (trig_stop) begin
                  state_q <= SQ_DRAIN;
               end
            end
            SQ_HOLD: begin
               if (trig_stop) begin
                  state_q <= SQ_IDLE;
               end else if (wr_fire) begin
                  if (next_found) begin
                     cur_q   <= next_ch;
                     state_q <= SQ_REQ;
                  end else begin
                     state_q <= SQ_IDLE;
                  end
               end
            end
            SQ_DRAIN: begin
               if (conv_valid) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != SQ_IDLE);
   assign conv_req = (state_q == SQ_REQ);
   assign conv_ch  = cur_q;
   assign have_res = (state_q == SQ_HOLD);
   assign res_data = res_q;

endmodule

// File: rtl/scan_dma_sampler.sv
module scan_dma_sampler
   import sdma_pkg::*;
#(
   parameter int unsigned NUM_CH       = 4,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned CNT_W        = 12,
   parameter bit          HAS_AUTOSTART = 1'b1,
   localparam int unsigned CH_W        = ch_index_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic              autostart_en,
   input  logic              trig_start,
   input  logic              trig_sample,
   input  logic              trig_stop,
   input  logic              stage_wr,
   input  logic [ADDR_W-1:0] stage_ptr,
   input  logic [CNT_W-1:0]  stage_len,
   output logic              ev_started,
   output logic              ev_end,
   output logic              busy,
   output logic [CNT_W-1:0]  amount,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_ch,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ready
);

   localparam int unsigned ADDR_STEP = DATA_W / 8;

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
      $error("scan_dma_sampler: NUM_CH must lie in 1..32");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_dw
      $error("scan_dma_sampler: DATA_W must be a whole number of bytes");
   end
   if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cw
      $error("scan_dma_sampler: CNT_W must lie in 1..31");
   end

   logic chain_en;
   logic armed;
   logic have_res;
   logic wr_fire;
   logic [DATA_W-1:0] res_data;

   if (HAS_AUTOSTART) begin : g_chain
      assign chain_en = autostart_en;
   end else begin : g_nochain
      logic unused_chain;
      assign unused_chain = autostart_en;
      assign chain_en     = 1'b0;
   end

   assign mem_valid = have_res & armed & ~trig_start & ~trig_stop;
   assign wr_fire   = mem_valid & mem_ready;
   assign mem_data  = res_data;

   sdma_buf_ctrl #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .ADDR_STEP (ADDR_STEP)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_start (trig_start),
      .trig_stop  (trig_stop),
      .chain_en   (chain_en),
      .stage_wr   (stage_wr),
      .stage_ptr  (stage_ptr),
      .stage_len  (stage_len),
      .wr_fire    (wr_fire),
      .armed      (armed),
      .ev_started (ev_started),
      .ev_end     (ev_end),
      .amount     (amount),
      .wr_addr    (mem_addr)
   );

   sdma_scan_seq #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_sample (trig_sample),
      .trig_stop   (trig_stop),
      .ch_enable   (ch_enable),
      .conv_valid  (conv_valid),
      .conv_data   (conv_data),
      .wr_fire     (wr_fire),
      .busy        (busy),
      .conv_req    (conv_req),
      .conv_ch     (conv_ch),
      .have_res    (have_res),
      .res_data    (res_data)
   );

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_start,
   input logic              trig_stop,
   input logic              ev_started,
   input logic              ev_end,
   input logic              busy,
   input logic [CNT_W-1:0]  amount,
   input logic              conv_req,
   input logic              mem_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic              mem_ready
);

   // R3: a converter request is only ever made during a scan
   a_r3_req_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> busy);

   // R4: start acknowledge comes with a cleared count
   a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ev_started |-> (amount == '0));

   // R5: no write is offered in the completion cycle
   a_r5_end_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      ev_end |-> !mem_valid);

   // R7: each accepted write adds exactly one to the count
   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> (amount == CNT_W'($past(amount) + 1'b1)));

   // R9: a stalled write holds its address and data
   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (trig_start || trig_stop ||
          (mem_valid && $stable(mem_addr) && $stable(mem_data))));

   // R10: nothing is written or requested right after a stop
   a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      trig_stop |=> (!mem_valid && !conv_req));

   // R11: a request lasts a single cycle
   a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

endmodule

bind scan_dma_sampler sdma_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_start (trig_start),
   .trig_stop  (trig_stop),
   .ev_started (ev_started),
   .ev_end     (ev_end),
   .busy       (busy),
   .amount     (amount),
   .conv_req   (conv_req),
   .mem_valid  (mem_valid),
   .mem_addr   (mem_addr),
   .mem_data   (mem_data),
   .mem_ready  (mem_ready)
);

// File: tb/scan_dma_sampler_tb.sv
`timescale 1ns/1ps
module scan_dma_sampler_tb;

   localparam int NCH = 4;
   localparam int DW  = 16;
   localparam int AW  = 32;
   localparam int CW  = 12;
   localparam int LAT = 3;
   localparam int CHW = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n = 1'b0;
   logic [NCH-1:0] ch_enable = '0;
   logic           autostart_en = 1'b0;
   logic           trig_start = 1'b0, trig_sample = 1'b0, trig_stop = 1'b0;
   logic           stage_wr = 1'b0;
   logic [AW-1:0]  stage_ptr = '0;
   logic [CW-1:0]  stage_len = '0;
   logic           ev_started, ev_end, busy, conv_req, mem_valid;
   logic [CW-1:0]  amount;
   logic [CHW-1:0] conv_ch;
   logic           conv_valid = 1'b0;
   logic [DW-1:0]  conv_data = '0;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_data;
   logic           mem_ready = 1'b1;

   scan_dma_sampler u_dut (
      .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .autostart_en(autostart_en),
      .trig_start(trig_start), .trig_sample(trig_sample), .trig_stop(trig_stop),
      .stage_wr(stage_wr), .stage_ptr(stage_ptr), .stage_len(stage_len),
      .ev_started(ev_started), .ev_end(ev_end), .busy(busy), .amount(amount),
      .conv_req(conv_req), .conv_ch(conv_ch), .conv_valid(conv_valid),
      .conv_data(conv_data), .mem_valid(mem_valid), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_ready(mem_ready)
   );

   int checks = 0, fails = 0, cyc = 0;
   int n_end = 0, n_start = 0, n_req = 0, nw = 0, end_cyc = 0, st_cyc = 0;
   logic [AW-1:0] log_addr [0:1023];
   logic [DW-1:0] log_data [0:1023];
   bit stall_mode = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 mem_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
   end

   // Monitor: events and accepted writes, sampled mid-cycle
   always @(negedge clk) begin
      if (ev_end)     begin n_end++;   end_cyc = cyc; end
      if (ev_started) begin n_start++; st_cyc  = cyc; end
      if (conv_req) n_req++;
      if (mem_valid && mem_ready && nw < 1024) begin
         log_addr[nw] = mem_addr;
         log_data[nw] = mem_data;
         nw++;
      end
   end

   // Converter model: tag = {channel, request sequence}, LAT cycles after request
   int cd = 0;
   int seq = 0;
   logic [DW-1:0] pend = '0;
   always @(negedge clk) begin
      conv_valid <= 1'b0;
      if (cd == 1) begin
         conv_valid <= 1'b1;
         conv_data  <= pend;
      end
      if (cd > 0) cd <= cd - 1;
      if (conv_req) begin
         cd   <= LAT;
         pend <= {4'(conv_ch), 12'(seq)};
         seq  <= seq + 1;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();  trig_start = 1'b1;  tick(); trig_start = 1'b0;  endtask
   task automatic pulse_sample(); trig_sample = 1'b1; tick(); trig_sample = 1'b0; endtask
   task automatic pulse_stop();   trig_stop = 1'b1;   tick(); trig_stop = 1'b0;   endtask

   task automatic stage(logic [AW-1:0] p, logic [CW-1:0] l);
      stage_wr = 1'b1; stage_ptr = p; stage_len = l;
      tick();
      stage_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int t = 0; t < 2000 && busy; t++) tick();
      tick(2);
   endtask

   // Check one logged write: address and channel tag
   task automatic chk_wr(int idx, logic [AW-1:0] ea, int ech, string tag);
      chk(log_addr[idx] == ea, {tag, " addr"}, log_addr[idx], ea);
      chk(int'(log_data[idx][15:12]) == ech, {tag, " chan"}, log_data[idx][15:12], ech);
   endtask

   initial begin
      #1000000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int w0, e0, r0;
      tick(3);
      // Reset state (R3, R7)
      chk(!busy && !conv_req, "R3 reset busy", busy, 0);
      chk(amount == 0 && !ev_started && !ev_end && !mem_valid, "R7 reset amount", amount, 0);
      rst_n = 1'b1;
      tick(2);

      // Sweep all non-empty masks, two scans per buffer (R1 R4 R5 R7 R9)
      for (int m = 1; m < 16; m++) begin
         int nch;
         int chs [4];
         logic [AW-1:0] p;
         nch = 0;
         for (int c = 0; c < 4; c++) if (m[c]) begin chs[nch] = c; nch++; end
         p = 32'h1000 + 32'(m) * 32'h100;
         stall_mode = m[0];
         ch_enable = 4'(m);
         stage(p, 12'(2 * nch));
         w0 = nw; e0 = n_end;
         pulse_start();
         chk(ev_started == 1'b1, "R4 started pulse", ev_started, 1);
         tick();
         chk(ev_started == 1'b0, "R4 started single", ev_started, 0);
         pulse_sample(); wait_idle();
         pulse_sample(); wait_idle();
         chk(nw - w0 == 2 * nch, "R1 write count", nw - w0, 2 * nch);
         chk(n_end - e0 == 1, "R5 end once", n_end - e0, 1);
         chk(int'(amount) == 2 * nch, "R7 amount", amount, 2 * nch);
         for (int k = 0; k < 2 * nch; k++)
            chk_wr(w0 + k, p + 32'(2 * k), chs[k % nch], "R1 R9 sweep");
      end
      stall_mode = 1'b0;

      // Second trigger during a scan, and an empty mask (R2 R3 R10)
      ch_enable = 4'hF;
      stage(32'h5000, 12'd8);
      pulse_start();
      w0 = nw; r0 = n_req;
      pulse_sample();
      chk(busy == 1'b1, "R3 busy after sample", busy, 1);
      pulse_sample();
      wait_idle();
      chk(n_req - r0 == 4, "R2 ignored sample requests", n_req - r0, 4);
      chk(nw - w0 == 4, "R2 ignored sample writes", nw - w0, 4);
      ch_enable = '0;
      pulse_sample();
      chk(busy == 1'b0, "R2 empty mask", busy, 0);
      tick(8);
      chk(n_req - r0 == 4, "R2 empty mask requests", n_req - r0, 4);
      e0 = n_end;
      pulse_stop(); tick(2);
      chk(n_end - e0 == 1, "R10 stop end", n_end - e0, 1);
      chk(amount == 4, "R10 amount frozen", amount, 4);

      // Buffer fills mid-scan: rotated order in the next buffer (R8 R4 R5)
      ch_enable = 4'hF;
      stage(32'h6000, 12'd6);
      pulse_start();
      stage(32'h7000, 12'd6);
      w0 = nw; e0 = n_end;
      pulse_sample(); wait_idle();
      pulse_sample();
      for (int t = 0; t < 200 && n_end == e0; t++) tick();
      tick(6);
      chk(busy == 1'b1, "R8 held busy", busy, 1);
      chk(amount == 6, "R5 full amount", amount, 6);
      chk(nw - w0 == 6, "R5 no write when full", nw - w0, 6);
      pulse_start(); wait_idle();
      pulse_sample(); wait_idle();
      chk(nw - w0 == 12, "R8 total writes", nw - w0, 12);
      for (int k = 0; k < 6; k++) chk_wr(w0 + k, 32'h6000 + 32'(2 * k), k % 4, "R8 first buf");
      for (int k = 0; k < 6; k++) chk_wr(w0 + 6 + k, 32'h7000 + 32'(2 * k), (k + 2) % 4, "R8 rotated");
      chk(n_end - e0 == 2, "R5 two ends", n_end - e0, 2);

      // Automatic restart onto the staged buffer (R6)
      autostart_en = 1'b1;
      stage(32'h8000, 12'd4);
      pulse_start();
      stage(32'h9000, 12'd4);
      w0 = nw;
      pulse_sample(); wait_idle(); tick(2);
      chk(st_cyc == end_cyc + 1, "R6 chained start", st_cyc, end_cyc + 1);
      chk(amount == 0, "R6 amount cleared", amount, 0);
      pulse_sample(); wait_idle(); tick(2);
      for (int k = 0; k < 4; k++) chk_wr(w0 + k, 32'h8000 + 32'(2 * k), k, "R6 first");
      for (int k = 0; k < 4; k++) chk_wr(w0 + 4 + k, 32'h9000 + 32'(2 * k), k, "R6 chained");
      autostart_en = 1'b0;
      tick(2);
      pulse_stop(); tick(2);

      // Stop between conversions, then a clean restart (R10 R11)
      stage(32'hA000, 12'd8);
      pulse_start();
      w0 = nw; e0 = n_end;
      pulse_sample();
      for (int t = 0; t < 200 && (nw - w0) < 2; t++) tick();
      pulse_stop();
      tick(3);
      chk(busy == 1'b0 || n_end - e0 == 1, "R10 stop end pulse", n_end - e0, 1);
      chk(amount == 2, "R10 partial amount", amount, 2);
      tick(20);
      chk(busy == 1'b0, "R10 idle after stop", busy, 0);
      chk(nw - w0 == 2, "R10 no write after stop", nw - w0, 2);
      stage(32'hB000, 12'd4);
      pulse_start();
      w0 = nw; r0 = n_req;
      pulse_sample(); wait_idle();
      chk(n_req - r0 == 4, "R11 one request per channel", n_req - r0, 4);
      for (int k = 0; k < 4; k++) chk_wr(w0 + k, 32'hB000 + 32'(2 * k), k, "R10 R11 restart");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule